// File: doc/BRIEF.md
# PLL Settings Guard with Unlock Sequence

This block holds the settings for an on-chip clock multiplier: a 5-bit multiplier code, a 2-bit post-divider code, and two control bits. One control bit powers the loop and the other hands the core clock to it. Software writes new values into shadow (pending) registers over a simple single-cycle register bus. The values reach the analog loop only when the software writes an unlock key pair, 0xAA and then 0x55, to a dedicated key register. Any other transfer on the bus between the two key writes breaks the pair, and no setting is applied.

The block reports the live settings and the lock state through a status register. It also drives the clock-select level that moves the core clock from the crystal oscillator to the loop output. This level goes high only when the applied settings have the loop powered and connected and the lock input, after synchronisation, is high. If lock drops, the select level falls back to the oscillator at once. The usual bring-up order is: power the loop, unlock, wait for lock, set connect, and unlock again.

Top module: `pll_feed_ctrl`

Register map (two address bits). Address 0 is control: bit 0 powers the loop and bit 1 connects it. Address 1 is configuration: bits 4:0 hold the multiplier code and bits 6:5 hold the divider code. Address 2 is status and is read only. Address 3 is the key register and reads as zero. `bus_rdata` shows the addressed register combinationally. Control and configuration read back their pending values.

## Requirements
- R1: After reset, all pending and applied settings are zero, the key sequence is idle, `clk_sel_pll_o` is 0, and status reads 0.
- R2: A write to address 1 stores bits 4:0 and 6:5 as the pending multiplier and divider codes, and readback of address 1 returns them. The applied settings and status do not change.
- R3: A key write of exactly 0x00AA, then as the very next bus transfer a key write of 0x0055, copies all pending values to the applied settings on the clock edge of the 0x0055 write. A repeated 0x00AA re-arms the sequence, so 0xAA, 0xAA, 0x55 also applies.
- R4: Any read, or any write to another address, between 0x00AA and 0x0055 cancels the sequence. The following 0x0055 applies nothing.
- R5: A key write of 0x0055 with no armed sequence, or a key write of any value other than the two keys (including 0x01AA), applies nothing and leaves the sequence idle.
- R6: `p_ratio_o` is a one-hot post-divider ratio decoded from the applied divider code: 00→1, 01→2, 10→4, 11→8.
- R7: Status bit 10 reports `lock_in` delayed by SYNC_STAGES clock edges, and only while the applied power bit is set. Otherwise it reads 0.
- R8: `clk_sel_pll_o` is 1 exactly when the applied power bit, the applied connect bit and the synchronised lock are all 1. A connect applied without power or without lock keeps the oscillator selected.
- R9: Loss of the synchronised lock while connected drops `clk_sel_pll_o` to 0 in the same cycle. It returns to 1 when lock returns.
- R10: Status shows the applied multiplier in bits 4:0, the divider code in bits 6:5, power in bit 8 and connect in bit 9. All other bits read 0.
- R11: A write to address 0 stores bit 0 (power) and bit 1 (connect) as pending values, and readback of address 0 returns them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus transfer in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Addressed register contents |
| lock_in | input | 1 | Raw lock indication from the analog loop |
| pll_en_o | output | 1 | Applied power bit |
| msel_o | output | 5 | Applied multiplier code |
| psel_o | output | 2 | Applied divider code |
| p_ratio_o | output | 4 | One-hot divider ratio |
| clk_sel_pll_o | output | 1 | 1 = core clock from loop, 0 = from oscillator |

## Verification
The bench builds the block with DATA_W = 16, SYNC_STAGES = 2 and the default keys 0xAA/0x55. With these values, the full 16-bit key compare can be exercised with a near-miss value such as 0x01AA, and the two-edge lock delay can be modelled exactly in a queue. A behavioural model tracks pending values, applied values, the armed flag and the lock history, and it checks every output on every cycle. Directed passes walk all four divider codes, break the key pair with a read and with a write, re-arm with a doubled 0xAA, and drop lock while connected.

// File: rtl/pll_feed_pkg.sv
package pll_feed_pkg;

    localparam int MSEL_W   = 5;
    localparam int PSEL_W   = 2;
    localparam int ADDR_W   = 2;
    localparam int EN_BIT   = 8;
    localparam int CON_BIT  = 9;
    localparam int LOCK_BIT = 10;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CFG  = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
    localparam logic [ADDR_W-1:0] A_FEED = 2'd3;

    typedef struct packed {
        logic              con;
        logic              en;
        logic [PSEL_W-1:0] psel;
        logic [MSEL_W-1:0] msel;
    } pll_set_t;

    typedef enum logic {
        FEED_IDLE,
        FEED_ARMED
    } feed_st_e;

endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sync_out = sh_q[STAGES-1];

endmodule

// File: rtl/pll_feed_seq.sv
module pll_feed_seq
    import pll_feed_pkg::*;
#(
    parameter int          DATA_W   = 16,
    parameter logic [7:0]  KEY_ARM  = 8'hAA,
    parameter logic [7:0]  KEY_FIRE = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              apply_o
);

    localparam logic [DATA_W-1:0] ARM_WORD  = DATA_W'(KEY_ARM);
    localparam logic [DATA_W-1:0] FIRE_WORD = DATA_W'(KEY_FIRE);

    feed_st_e st_d, st_q;
    logic     key_wr;

    always_comb begin
        st_d    = st_q;
        apply_o = 1'b0;
        key_wr  = bus_sel && bus_wr && (bus_addr == A_FEED);
        if (bus_sel) begin
            if (key_wr && bus_wdata == ARM_WORD) begin
                st_d = FEED_ARMED;
            end else if (key_wr && bus_wdata == FIRE_WORD && st_q == FEED_ARMED) begin
                apply_o = 1'b1;
                st_d    = FEED_IDLE;
            end else begin
                st_d = FEED_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FEED_IDLE;
        else        st_q <= st_d;
    end

    // R4: a foreign transfer while armed leaves the sequence idle
    a_r4_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FEED_ARMED && bus_sel && !key_wr) |=> (st_q == FEED_IDLE));

    // R5: nothing is applied unless the sequence was armed
    a_r5_no_cold_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FEED_IDLE) |-> !apply_o);

endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
    import pll_feed_pkg::*;
#(
    parameter int SET_W = MSEL_W + PSEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_cfg,
    input  logic [SET_W-1:0] wdata,
    input  logic             apply,
    output pll_set_t         pend_o,
    output pll_set_t         act_o
);

    typedef struct packed {
        pll_set_t pend;
        pll_set_t act;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) begin
            r_d.pend.en  = wdata[0];
            r_d.pend.con = wdata[1];
        end
        if (wr_cfg) begin
            r_d.pend.msel = wdata[MSEL_W-1:0];
            r_d.pend.psel = wdata[MSEL_W +: PSEL_W];
        end
        if (apply) begin
            r_d.act = r_q.pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pend_o = r_q.pend;
    assign act_o  = r_q.act;

    // R3: applied settings move only on an apply
    a_r3_act_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(r_q.act));

    // R2: a configuration write lands in the pending multiplier
    a_r2_pend_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cfg |=> (r_q.pend.msel == $past(wdata[MSEL_W-1:0])));

endmodule

// File: rtl/pll_feed_ctrl.sv
module pll_feed_ctrl
    import pll_feed_pkg::*;
#(
    parameter int         DATA_W      = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] KEY_ARM     = 8'hAA,
    parameter logic [7:0] KEY_FIRE    = 8'h55
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  lock_in,
    output logic                  pll_en_o,
    output logic [MSEL_W-1:0]     msel_o,
    output logic [PSEL_W-1:0]     psel_o,
    output logic [(1<<PSEL_W)-1:0] p_ratio_o,
    output logic                  clk_sel_pll_o
);

    localparam int RATIO_W = 1 << PSEL_W;
    localparam int SET_W   = MSEL_W + PSEL_W;

    logic              apply_w;
    logic              lock_s;
    logic              wr_ctrl, wr_cfg;
    pll_set_t          pend, act;
    logic [DATA_W-1:0] status_w;

    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == A_CTRL);
    assign wr_cfg  = bus_sel && bus_wr && (bus_addr == A_CFG);

    pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (lock_in),
        .sync_out (lock_s)
    );

    pll_feed_seq #(.DATA_W(DATA_W), .KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .apply_o   (apply_w)
    );

    pll_cfg_regs #(.SET_W(SET_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_cfg  (wr_cfg),
        .wdata   (bus_wdata[SET_W-1:0]),
        .apply   (apply_w),
        .pend_o  (pend),
        .act_o   (act)
    );

    always_comb begin
        status_w                     = '0;
        status_w[MSEL_W-1:0]         = act.msel;
        status_w[MSEL_W +: PSEL_W]   = act.psel;
        status_w[EN_BIT]             = act.en;
        status_w[CON_BIT]            = act.con;
        status_w[LOCK_BIT]           = lock_s && act.en;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[0] = pend.en;
                bus_rdata[1] = pend.con;
            end
            A_CFG: begin
                bus_rdata[MSEL_W-1:0]       = pend.msel;
                bus_rdata[MSEL_W +: PSEL_W] = pend.psel;
            end
            A_STAT:  bus_rdata = status_w;
            default: bus_rdata = '0;
        endcase
    end

    generate
        for (genvar gi = 0; gi < RATIO_W; gi++) begin : g_ratio
            assign p_ratio_o[gi] = (act.psel == PSEL_W'(gi));
        end
    endgenerate

    assign pll_en_o      = act.en;
    assign msel_o        = act.msel;
    assign psel_o        = act.psel;
    assign clk_sel_pll_o = act.en && act.con && lock_s;

    // R8: the loop clock is selected only with synchronised lock
    a_r8_sel_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel_pll_o |-> (lock_s && pll_en_o));

    // R9: a falling lock drops the select at once
    a_r9_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_s) |-> !clk_sel_pll_o);

    // R6: divider ratio is always exactly one-hot
    a_r6_ratio_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(p_ratio_o) == 1);

    // R7: lock is masked while the loop is powered down
    a_r7_lock_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en_o |-> !status_w[LOCK_BIT]);

endmodule

// File: tb/tb_pll_feed_ctrl.sv
module tb_pll_feed_ctrl;

    localparam int CLK_PERIOD  = 10;
    localparam int DATA_W      = 16;
    localparam int SYNC_STAGES = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [1:0]        bus_addr = 2'd0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              lock_in = 1'b0;
    logic              pll_en_o;
    logic [4:0]        msel_o;
    logic [1:0]        psel_o;
    logic [3:0]        p_ratio_o;
    logic              clk_sel_pll_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_feed_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_sel       (bus_sel),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .lock_in       (lock_in),
        .pll_en_o      (pll_en_o),
        .msel_o        (msel_o),
        .psel_o        (psel_o),
        .p_ratio_o     (p_ratio_o),
        .clk_sel_pll_o (clk_sel_pll_o)
    );

    // behavioural reference model
    bit       m_p_en, m_p_con, m_a_en, m_a_con, m_armed;
    bit [4:0] m_p_msel, m_a_msel;
    bit [1:0] m_p_psel, m_a_psel;
    bit       m_hist[$];

    task automatic model_reset();
        m_p_en = 0; m_p_con = 0; m_a_en = 0; m_a_con = 0; m_armed = 0;
        m_p_msel = 0; m_a_msel = 0; m_p_psel = 0; m_a_psel = 0;
        m_hist = {};
        for (int i = 0; i < SYNC_STAGES; i++) m_hist.push_back(1'b0);
    endtask

    initial model_reset();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            m_hist.push_front(lock_in);
            while (m_hist.size() > SYNC_STAGES) void'(m_hist.pop_back());
            if (bus_sel) begin
                if (bus_wr && bus_addr == 2'd0) begin
                    m_p_en = bus_wdata[0]; m_p_con = bus_wdata[1];
                end
                if (bus_wr && bus_addr == 2'd1) begin
                    m_p_msel = bus_wdata[4:0]; m_p_psel = bus_wdata[6:5];
                end
                if (bus_wr && bus_addr == 2'd3 && bus_wdata == 16'h00AA) begin
                    m_armed = 1;
                end else if (bus_wr && bus_addr == 2'd3 && bus_wdata == 16'h0055 && m_armed) begin
                    m_a_en = m_p_en; m_a_con = m_p_con;
                    m_a_msel = m_p_msel; m_a_psel = m_p_psel;
                    m_armed = 0;
                end else begin
                    m_armed = 0;
                end
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_status();
        logic [15:0] s;
        s = '0;
        s[4:0] = m_a_msel;
        s[6:5] = m_a_psel;
        s[8]   = m_a_en;
        s[9]   = m_a_con;
        s[10]  = m_hist[SYNC_STAGES-1] & m_a_en;
        return s;
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic [15:0] er;
            case (bus_addr)
                2'd0:    er = {14'd0, m_p_con, m_p_en};
                2'd1:    er = {9'd0, m_p_psel, m_p_msel};
                2'd2:    er = exp_status();
                default: er = 16'd0;
            endcase
            chk("R8 clk_sel", 32'(clk_sel_pll_o),
                32'(m_a_en & m_a_con & m_hist[SYNC_STAGES-1]));
            chk("R6 p_ratio", 32'(p_ratio_o), 32'(4'b0001 << m_a_psel));
            chk("R3 msel_o", 32'(msel_o), 32'(m_a_msel));
            chk("R3 psel_o", 32'(psel_o), 32'(m_a_psel));
            chk("R3 pll_en_o", 32'(pll_en_o), 32'(m_a_en));
            chk("R10 rdata", 32'(bus_rdata), 32'(er));
        end
    end

    task automatic xfer(bit wr, logic [1:0] a, logic [15:0] d);
        @(posedge clk); #2;
        bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic feed();
        xfer(1, 2'd3, 16'h00AA);
        xfer(1, 2'd3, 16'h0055);
    endtask

    task automatic peek(logic [1:0] a, string tag, logic [15:0] exp);
        @(posedge clk); #2;
        bus_addr = a;
        @(negedge clk);
        chk(tag, 32'(bus_rdata), 32'(exp));
    endtask

    task automatic sel_is(string tag, bit exp);
        @(negedge clk);
        chk(tag, 32'(clk_sel_pll_o), 32'(exp));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL all requirements: watchdog expired, actual hung expected done");
        summary();
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 clk_sel in reset", 32'(clk_sel_pll_o), 0);
        chk("R1 pll_en in reset", 32'(pll_en_o), 0);
        bus_addr = 2'd2;
        @(negedge clk);
        chk("R1 status in reset", 32'(bus_rdata), 0);
        @(posedge clk); #2 rst_n = 1;

        // R2 / R11 pending writes do not touch applied state
        xfer(1, 2'd1, 16'h0024);
        xfer(1, 2'd0, 16'h0001);
        peek(2'd1, "R2 cfg readback", 16'h0024);
        peek(2'd0, "R11 ctrl readback", 16'h0001);
        peek(2'd2, "R2 status unchanged", 16'h0000);

        // R3 apply
        feed();
        peek(2'd2, "R3 status after feed", 16'h0124);
        chk("R6 ratio for code 01", 32'(p_ratio_o), 32'h2);

        // R7 lock after sync delay
        @(posedge clk); #2 lock_in = 1;
        @(negedge clk);
        chk("R7 lock not yet visible", 32'(bus_rdata[10]), 0);
        repeat (3) @(posedge clk);
        peek(2'd2, "R7 lock reported", 16'h0524);

        // R4 abort by read and by write
        xfer(1, 2'd0, 16'h0003);
        xfer(1, 2'd3, 16'h00AA);
        xfer(0, 2'd2, 16'h0000);
        xfer(1, 2'd3, 16'h0055);
        sel_is("R4 read aborts", 0);
        xfer(1, 2'd3, 16'h00AA);
        xfer(1, 2'd1, 16'h0024);
        xfer(1, 2'd3, 16'h0055);
        peek(2'd2, "R4 write aborts", 16'h0524);

        // R5 lone fire key and wrong keys
        xfer(1, 2'd3, 16'h0055);
        sel_is("R5 lone 0x55", 0);
        xfer(1, 2'd3, 16'h00AA);
        xfer(1, 2'd3, 16'h0012);
        xfer(1, 2'd3, 16'h0055);
        sel_is("R5 wrong key", 0);
        xfer(1, 2'd3, 16'h01AA);
        xfer(1, 2'd3, 16'h0055);
        peek(2'd2, "R5 near-miss key", 16'h0524);

        // R3 re-arm, R8 connect
        xfer(1, 2'd3, 16'h00AA);
        feed();
        sel_is("R8 connected", 1);
        peek(2'd2, "R10 status connected", 16'h0724);

        // R9 lock loss
        @(posedge clk); #2 lock_in = 0;
        repeat (3) @(posedge clk);
        sel_is("R9 fallback", 0);
        peek(2'd2, "R9 status lock lost", 16'h0324);
        @(posedge clk); #2 lock_in = 1;
        repeat (3) @(posedge clk);
        sel_is("R9 recovered", 1);

        // R6 every divider code
        for (int p = 0; p < 4; p++) begin
            xfer(1, 2'd1, 16'((p << 5) | 5));
            feed();
            @(negedge clk);
            chk("R6 ratio", 32'(p_ratio_o), 32'(1 << p));
            chk("R6 psel_o", 32'(psel_o), 32'(p));
        end

        // R8 / R7 connect without power
        xfer(1, 2'd0, 16'h0002);
        feed();
        sel_is("R8 no power", 0);
        peek(2'd2, "R7 lock masked", 16'h0265);

        // R8 connect without lock
        @(posedge clk); #2 lock_in = 0;
        xfer(1, 2'd0, 16'h0003);
        feed();
        sel_is("R8 no lock", 0);
        @(posedge clk); #2 lock_in = 1;
        repeat (3) @(posedge clk);
        sel_is("R8 lock arrives", 1);

        // R1 mid-run reset
        @(posedge clk); #2 rst_n = 0;
        @(negedge clk);
        chk("R1 reset clears select", 32'(clk_sel_pll_o), 0);
        chk("R1 reset clears msel", 32'(msel_o), 0);
        @(posedge clk); #2 rst_n = 1;
        peek(2'd2, "R1 status after reset", 16'h0000);
        repeat (2) @(posedge clk);
        summary();
    end

endmodule